// File: doc/BRIEF.md
# DRAM Power State Controller

This block follows the power state of a single memory device, driven by command events that an upstream packet decoder has already extracted. Every cycle it may see a row-activate packet strobe, a row-command packet strobe carrying any mix of attention, relax, nap and power-down codes, two kinds of column packet strobes that can carry relax, and device-addressed read and write commands. Each row packet comes with a broadcast flag and a device-match flag. A sideband detector supplies a separate low-power exit event.

The controller keeps six states: REST (the resting state), ACTIVE (attention), ACT_RD and ACT_WR (attention after a read or a write), NAP and DOWN (power-down). When it enters NAP or DOWN it records whether the device should come back to REST or to ACTIVE. It then opens a quiet window of programmable length. During that window, any broadcast packet or any packet addressed to this device is an error. On each accepted entry it also checks that all banks are idle and the write buffer is empty. Any breach of the quiet window or of the entry preconditions sets a sticky violation flag.

The transitions are: REST→ACTIVE (attention), ACTIVE→ACT_WR or ACT_RD (write/read), ACT_RD↔ACT_WR (write/read), ACTIVE/ACT_RD/ACT_WR→REST (relax), REST/ACTIVE→NAP or DOWN (nap/power-down entry), and NAP/DOWN→REST or ACTIVE (exit to the recorded state).

Top module: `dram_pwr_ctl`

## Requirements
- R1: A synchronous active-high `rst` forces REST, clears the recorded return state, and drives `quiet_busy` and `violation` low. `state_oh` is one-hot with bit 0 REST, bit 1 ACTIVE, bit 2 ACT_RD, bit 3 ACT_WR, bit 4 NAP, bit 5 DOWN, and it changes one cycle after the command that causes the change.
- R2: In REST, an addressed non-broadcast row-activate packet, or an addressed non-broadcast row-command packet with the attention code, moves the device to ACTIVE. The broadcast forms of both packets leave the state unchanged.
- R3: From ACTIVE, a write moves the device to ACT_WR and a read moves it to ACT_RD. From ACT_RD a write moves it to ACT_WR, and from ACT_WR a read moves it to ACT_RD. If read and write arrive in the same cycle, the write wins.
- R4: In ACTIVE, ACT_RD or ACT_WR, a relax code in an addressed row-command packet or in either addressed column packet returns the device to REST. A relax in REST has no effect.
- R5: A broadcast row-command packet with the relax code returns the device to REST from ACTIVE, ACT_RD or ACT_WR.
- R6: An addressed non-broadcast nap or power-down code is accepted only in REST or ACTIVE. It is ignored in ACT_RD and ACT_WR. If both codes arrive together, power-down wins.
- R7: `lp_exit` in NAP or DOWN returns the device to the state it was in when it entered: REST or ACTIVE. In any other state `lp_exit` is ignored.
- R8: If the accepted entry packet also carries relax while the device is in ACTIVE, the exit goes to REST instead of ACTIVE.
- R9: After an accepted entry, `quiet_busy` stays high for `quiet_len` cycles. A broadcast row packet, or any packet matching this device, that arrives while `quiet_busy` is high sets `violation`. A non-matching, non-broadcast packet does not.
- R10: An accepted entry sets `violation` when `banks_idle` or `wbuf_empty` is low in the entry cycle. A nap entry with `nap_sr_en` low is exempt.
- R11: Relax, nap and power-down codes in packets whose match flag is low are ignored, and so are row-activate packets whose match flag is low.
- R12: `violation` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_vld | input | 1 | Row-activate packet strobe |
| act_bcast | input | 1 | Row-activate packet is broadcast |
| act_hit | input | 1 | Row-activate packet matches this device |
| rcmd_vld | input | 1 | Row-command packet strobe |
| rcmd_bcast | input | 1 | Row-command packet is broadcast |
| rcmd_hit | input | 1 | Row-command packet matches this device |
| rcmd_attn | input | 1 | Row-command carries attention |
| rcmd_relax | input | 1 | Row-command carries relax |
| rcmd_nap | input | 1 | Row-command carries nap |
| rcmd_pdn | input | 1 | Row-command carries power-down |
| ccmd_vld | input | 1 | First column packet strobe |
| ccmd_hit | input | 1 | First column packet matches this device |
| ccmd_relax | input | 1 | First column packet carries relax |
| xcmd_vld | input | 1 | Second column packet strobe |
| xcmd_hit | input | 1 | Second column packet matches this device |
| xcmd_relax | input | 1 | Second column packet carries relax |
| rd_cmd | input | 1 | Read command for this device |
| wr_cmd | input | 1 | Write command for this device |
| lp_exit | input | 1 | Low-power exit event from sideband detector |
| banks_idle | input | 1 | All banks precharged |
| wbuf_empty | input | 1 | Write buffer retired |
| nap_sr_en | input | 1 | Self-refresh during nap enabled |
| quiet_len | input | QUIET_W (8) | Quiet window length in cycles |
| state_oh | output | 6 | One-hot power state |
| quiet_busy | output | 1 | Quiet window open |
| violation | output | 1 | Sticky rule-breach flag |

## Verification
The hardest situation to reach is the last cycle of the quiet window. A packet arriving in that cycle must still count as a breach, while a packet one cycle later must not. The stimulus loads a short window of three cycles. It sends a foreign, non-broadcast packet in the first cycle to confirm that such traffic is tolerated, idles up to the closing edge, and then places an addressed column packet exactly on that edge. A second run lets the window lapse before sending an addressed packet. The recorded-return path is reached by entering from ACTIVE with and without relax, and comparing where `lp_exit` lands.

// File: rtl/dram_pwr_pkg.sv
package dram_pwr_pkg;

    localparam int NSTATE = 6;

    typedef enum logic [2:0] {
        PS_REST   = 3'd0,
        PS_ACTIVE = 3'd1,
        PS_ACT_RD = 3'd2,
        PS_ACT_WR = 3'd3,
        PS_NAP    = 3'd4,
        PS_DOWN   = 3'd5
    } pwr_state_e;

    typedef struct packed {
        logic attn;
        logic relax;
        logic nap;
        logic pdn;
        logic entry_relax;
        logic rd;
        logic wr;
        logic exit_req;
        logic touch;
    } pwr_ev_t;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
    import dram_pwr_pkg::*;
(
    input  logic    act_vld,
    input  logic    act_bcast,
    input  logic    act_hit,
    input  logic    rcmd_vld,
    input  logic    rcmd_bcast,
    input  logic    rcmd_hit,
    input  logic    rcmd_attn,
    input  logic    rcmd_relax,
    input  logic    rcmd_nap,
    input  logic    rcmd_pdn,
    input  logic    ccmd_vld,
    input  logic    ccmd_hit,
    input  logic    ccmd_relax,
    input  logic    xcmd_vld,
    input  logic    xcmd_hit,
    input  logic    xcmd_relax,
    input  logic    rd_cmd,
    input  logic    wr_cmd,
    input  logic    lp_exit,
    output pwr_ev_t ev
);

    logic act_own;
    logic rcmd_own;
    logic row_relax;
    logic col_relax;

    always_comb begin
        act_own   = act_vld && act_hit && !act_bcast;
        rcmd_own  = rcmd_vld && rcmd_hit && !rcmd_bcast;
        // broadcast relax is honoured, broadcast attention is not
        row_relax = rcmd_vld && rcmd_relax && (rcmd_bcast || rcmd_hit);
        col_relax = (ccmd_vld && ccmd_hit && ccmd_relax)
                 || (xcmd_vld && xcmd_hit && xcmd_relax);

        ev.attn        = act_own || (rcmd_own && rcmd_attn);
        ev.relax       = row_relax || col_relax;
        ev.nap         = rcmd_own && rcmd_nap;
        ev.pdn         = rcmd_own && rcmd_pdn;
        ev.entry_relax = rcmd_own && rcmd_relax;
        ev.rd          = rd_cmd;
        ev.wr          = wr_cmd;
        ev.exit_req    = lp_exit;
        ev.touch       = (act_vld && (act_bcast || act_hit))
                      || (rcmd_vld && (rcmd_bcast || rcmd_hit))
                      || (ccmd_vld && ccmd_hit)
                      || (xcmd_vld && xcmd_hit);
    end

endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
    import dram_pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pwr_ev_t           ev,
    output logic              entry_ok,
    output logic              entry_nap,
    output logic [NSTATE-1:0] state_oh
);

    pwr_state_e state_q, state_d;
    logic       ret_act_q, ret_act_d;
    logic       lp_req;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_REST;
            ret_act_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            ret_act_q <= ret_act_d;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        ret_act_d = ret_act_q;
        entry_ok  = 1'b0;
        lp_req    = ev.nap || ev.pdn;
        unique case (state_q)
            PS_REST: begin
                if (lp_req) begin
                    entry_ok  = 1'b1;
                    ret_act_d = 1'b0;
                    state_d   = ev.pdn ? PS_DOWN : PS_NAP;
                end else if (ev.attn) begin
                    state_d = PS_ACTIVE;
                end
            end
            PS_ACTIVE: begin
                if (lp_req) begin
                    entry_ok  = 1'b1;
                    ret_act_d = !ev.entry_relax;
                    state_d   = ev.pdn ? PS_DOWN : PS_NAP;
                end else if (ev.relax) begin
                    state_d = PS_REST;
                end else if (ev.wr) begin
                    state_d = PS_ACT_WR;
                end else if (ev.rd) begin
                    state_d = PS_ACT_RD;
                end
            end
            PS_ACT_RD: begin
                if (ev.relax) begin
                    state_d = PS_REST;
                end else if (ev.wr) begin
                    state_d = PS_ACT_WR;
                end
            end
            PS_ACT_WR: begin
                if (ev.relax) begin
                    state_d = PS_REST;
                end else if (ev.rd) begin
                    state_d = PS_ACT_RD;
                end
            end
            PS_NAP, PS_DOWN: begin
                if (ev.exit_req) begin
                    state_d = ret_act_q ? PS_ACTIVE : PS_REST;
                end
            end
            default: begin
                state_d = PS_REST;
            end
        endcase
    end

    // outputs
    always_comb begin
        entry_nap = entry_ok && !ev.pdn;
        for (int i = 0; i < NSTATE; i++) begin
            state_oh[i] = (state_q == pwr_state_e'(i));
        end
    end

    // R6
    no_lp_from_rdwr_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_ACT_RD || state_q == PS_ACT_WR)
        |=> !(state_q == PS_NAP || state_q == PS_DOWN));

    // R7
    exit_target_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == PS_NAP || state_q == PS_DOWN) && ev.exit_req)
        |=> (state_q == PS_REST || state_q == PS_ACTIVE));

    // R3
    read_move_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_ACTIVE && ev.rd && !ev.wr && !ev.relax && !ev.nap && !ev.pdn)
        |=> state_q == PS_ACT_RD);

endmodule

// File: rtl/pwr_quiet_window.sv
module pwr_quiet_window #(
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [QUIET_W-1:0] len,
    output logic               busy
);

    localparam logic [QUIET_W-1:0] CNT_ZERO = '0;
    localparam logic [QUIET_W-1:0] CNT_ONE  = QUIET_W'(1);

    logic [QUIET_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
        end else if (load) begin
            cnt_q <= len;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    always_comb begin
        busy = (cnt_q != CNT_ZERO);
    end

    // R9
    quiet_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/pwr_violation_mon.sv
module pwr_violation_mon (
    input  logic clk,
    input  logic rst,
    input  logic quiet_busy,
    input  logic touch,
    input  logic entry_ok,
    input  logic entry_nap,
    input  logic banks_idle,
    input  logic wbuf_empty,
    input  logic nap_sr_en,
    output logic violation
);

    logic viol_q;
    logic quiet_hit;
    logic precond_bad;

    always_comb begin
        quiet_hit   = quiet_busy && touch;
        precond_bad = entry_ok && !(banks_idle && wbuf_empty)
                   && !(entry_nap && !nap_sr_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_q <= 1'b0;
        end else if (quiet_hit || precond_bad) begin
            viol_q <= 1'b1;
        end
    end

    always_comb begin
        violation = viol_q;
    end

    // R12
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        violation |=> violation);

    // R10
    exempt_nap_chk: assert property (@(posedge clk) disable iff (rst)
        (!violation && entry_nap && !nap_sr_en && !quiet_hit) |=> !violation);

endmodule

// File: rtl/dram_pwr_ctl.sv
module dram_pwr_ctl
    import dram_pwr_pkg::*;
#(
    parameter int QUIET_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               act_vld,
    input  logic               act_bcast,
    input  logic               act_hit,
    input  logic               rcmd_vld,
    input  logic               rcmd_bcast,
    input  logic               rcmd_hit,
    input  logic               rcmd_attn,
    input  logic               rcmd_relax,
    input  logic               rcmd_nap,
    input  logic               rcmd_pdn,
    input  logic               ccmd_vld,
    input  logic               ccmd_hit,
    input  logic               ccmd_relax,
    input  logic               xcmd_vld,
    input  logic               xcmd_hit,
    input  logic               xcmd_relax,
    input  logic               rd_cmd,
    input  logic               wr_cmd,
    input  logic               lp_exit,
    input  logic               banks_idle,
    input  logic               wbuf_empty,
    input  logic               nap_sr_en,
    input  logic [QUIET_W-1:0] quiet_len,
    output logic [5:0]         state_oh,
    output logic               quiet_busy,
    output logic               violation
);

    pwr_ev_t ev;
    logic    entry_ok;
    logic    entry_nap;

    pwr_cmd_decode dec_i (
        .act_vld    (act_vld),
        .act_bcast  (act_bcast),
        .act_hit    (act_hit),
        .rcmd_vld   (rcmd_vld),
        .rcmd_bcast (rcmd_bcast),
        .rcmd_hit   (rcmd_hit),
        .rcmd_attn  (rcmd_attn),
        .rcmd_relax (rcmd_relax),
        .rcmd_nap   (rcmd_nap),
        .rcmd_pdn   (rcmd_pdn),
        .ccmd_vld   (ccmd_vld),
        .ccmd_hit   (ccmd_hit),
        .ccmd_relax (ccmd_relax),
        .xcmd_vld   (xcmd_vld),
        .xcmd_hit   (xcmd_hit),
        .xcmd_relax (xcmd_relax),
        .rd_cmd     (rd_cmd),
        .wr_cmd     (wr_cmd),
        .lp_exit    (lp_exit),
        .ev         (ev)
    );

    pwr_state_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .entry_ok  (entry_ok),
        .entry_nap (entry_nap),
        .state_oh  (state_oh)
    );

    pwr_quiet_window #(.QUIET_W(QUIET_W)) qw_i (
        .clk  (clk),
        .rst  (rst),
        .load (entry_ok),
        .len  (quiet_len),
        .busy (quiet_busy)
    );

    pwr_violation_mon vm_i (
        .clk        (clk),
        .rst        (rst),
        .quiet_busy (quiet_busy),
        .touch      (ev.touch),
        .entry_ok   (entry_ok),
        .entry_nap  (entry_nap),
        .banks_idle (banks_idle),
        .wbuf_empty (wbuf_empty),
        .nap_sr_en  (nap_sr_en),
        .violation  (violation)
    );

    // R1
    onehot_state_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_oh) == 1);

endmodule

// File: tb/dram_pwr_ctl_tb.sv
module dram_pwr_ctl_tb_top;

    localparam logic [5:0] S_REST = 6'b000001;
    localparam logic [5:0] S_ACT  = 6'b000010;
    localparam logic [5:0] S_RD   = 6'b000100;
    localparam logic [5:0] S_WR   = 6'b001000;
    localparam logic [5:0] S_NAP  = 6'b010000;
    localparam logic [5:0] S_DOWN = 6'b100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic act_vld, act_bcast, act_hit;
    logic rcmd_vld, rcmd_bcast, rcmd_hit, rcmd_attn, rcmd_relax, rcmd_nap, rcmd_pdn;
    logic ccmd_vld, ccmd_hit, ccmd_relax, xcmd_vld, xcmd_hit, xcmd_relax;
    logic rd_cmd, wr_cmd, lp_exit, banks_idle, wbuf_empty, nap_sr_en;
    logic [7:0] quiet_len;
    logic [5:0] state_oh;
    logic quiet_busy, violation;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dram_pwr_ctl #(.QUIET_W(8)) dut_i (
        .clk(clk), .rst(rst),
        .act_vld(act_vld), .act_bcast(act_bcast), .act_hit(act_hit),
        .rcmd_vld(rcmd_vld), .rcmd_bcast(rcmd_bcast), .rcmd_hit(rcmd_hit),
        .rcmd_attn(rcmd_attn), .rcmd_relax(rcmd_relax), .rcmd_nap(rcmd_nap),
        .rcmd_pdn(rcmd_pdn),
        .ccmd_vld(ccmd_vld), .ccmd_hit(ccmd_hit), .ccmd_relax(ccmd_relax),
        .xcmd_vld(xcmd_vld), .xcmd_hit(xcmd_hit), .xcmd_relax(xcmd_relax),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .lp_exit(lp_exit),
        .banks_idle(banks_idle), .wbuf_empty(wbuf_empty), .nap_sr_en(nap_sr_en),
        .quiet_len(quiet_len),
        .state_oh(state_oh), .quiet_busy(quiet_busy), .violation(violation)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        act_vld = 0; act_bcast = 0; act_hit = 0;
        rcmd_vld = 0; rcmd_bcast = 0; rcmd_hit = 0; rcmd_attn = 0;
        rcmd_relax = 0; rcmd_nap = 0; rcmd_pdn = 0;
        ccmd_vld = 0; ccmd_hit = 0; ccmd_relax = 0;
        xcmd_vld = 0; xcmd_hit = 0; xcmd_relax = 0;
        rd_cmd = 0; wr_cmd = 0; lp_exit = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        banks_idle = 1; wbuf_empty = 1; nap_sr_en = 1; quiet_len = 8'd0;
        rst = 1;
        step();
        step();
        rst = 0;
    endtask

    task automatic go_active();
        act_vld = 1; act_hit = 1;
        step();
    endtask

    task automatic row_cmd(input logic bc, input logic hit, input logic at,
                           input logic rx, input logic np, input logic pd);
        rcmd_vld = 1; rcmd_bcast = bc; rcmd_hit = hit; rcmd_attn = at;
        rcmd_relax = rx; rcmd_nap = np; rcmd_pdn = pd;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state", {2'b0, state_oh}, {2'b0, S_REST});
        check("R1 busy", {7'b0, quiet_busy}, 8'd0);
        check("R1 viol", {7'b0, violation}, 8'd0);
    endtask

    task automatic t_attn();
        do_reset();
        act_vld = 1; act_bcast = 1; act_hit = 1; step();
        check("R2 bcast act", {2'b0, state_oh}, {2'b0, S_REST});
        row_cmd(1, 1, 1, 0, 0, 0);
        check("R2 bcast attn", {2'b0, state_oh}, {2'b0, S_REST});
        act_vld = 1; act_hit = 0; step();
        check("R11 foreign act", {2'b0, state_oh}, {2'b0, S_REST});
        go_active();
        check("R2 act", {2'b0, state_oh}, {2'b0, S_ACT});
        do_reset();
        row_cmd(0, 1, 1, 0, 0, 0);
        check("R2 rcmd attn", {2'b0, state_oh}, {2'b0, S_ACT});
    endtask

    task automatic t_rdwr();
        do_reset();
        go_active();
        rd_cmd = 1; step();
        check("R3 act->rd", {2'b0, state_oh}, {2'b0, S_RD});
        wr_cmd = 1; step();
        check("R3 rd->wr", {2'b0, state_oh}, {2'b0, S_WR});
        rd_cmd = 1; step();
        check("R3 wr->rd", {2'b0, state_oh}, {2'b0, S_RD});
        do_reset();
        go_active();
        rd_cmd = 1; wr_cmd = 1; step();
        check("R3 write wins", {2'b0, state_oh}, {2'b0, S_WR});
    endtask

    task automatic t_relax();
        do_reset();
        go_active();
        wr_cmd = 1; step();
        ccmd_vld = 1; ccmd_hit = 0; ccmd_relax = 1; step();
        check("R11 foreign relax", {2'b0, state_oh}, {2'b0, S_WR});
        ccmd_vld = 1; ccmd_hit = 1; ccmd_relax = 1; step();
        check("R4 col relax", {2'b0, state_oh}, {2'b0, S_REST});
        go_active();
        xcmd_vld = 1; xcmd_hit = 1; xcmd_relax = 1; step();
        check("R4 xcol relax", {2'b0, state_oh}, {2'b0, S_REST});
        row_cmd(0, 1, 0, 1, 0, 0);
        check("R4 relax in rest", {2'b0, state_oh}, {2'b0, S_REST});
        go_active();
        row_cmd(0, 1, 0, 1, 0, 0);
        check("R4 row relax", {2'b0, state_oh}, {2'b0, S_REST});
        go_active();
        rd_cmd = 1; step();
        row_cmd(1, 0, 0, 1, 0, 0);
        check("R5 bcast relax", {2'b0, state_oh}, {2'b0, S_REST});
    endtask

    task automatic t_entry();
        do_reset();
        row_cmd(0, 1, 0, 0, 1, 0);
        check("R6 nap from rest", {2'b0, state_oh}, {2'b0, S_NAP});
        lp_exit = 1; step();
        check("R7 exit to rest", {2'b0, state_oh}, {2'b0, S_REST});
        go_active();
        lp_exit = 1; step();
        check("R7 exit ignored", {2'b0, state_oh}, {2'b0, S_ACT});
        row_cmd(0, 1, 0, 0, 0, 1);
        check("R6 pdn from act", {2'b0, state_oh}, {2'b0, S_DOWN});
        lp_exit = 1; step();
        check("R7 exit to act", {2'b0, state_oh}, {2'b0, S_ACT});
        row_cmd(0, 0, 0, 0, 1, 0);
        check("R11 foreign nap", {2'b0, state_oh}, {2'b0, S_ACT});
        row_cmd(0, 1, 0, 0, 1, 1);
        check("R6 pdn wins", {2'b0, state_oh}, {2'b0, S_DOWN});
        lp_exit = 1; step();
        rd_cmd = 1; step();
        row_cmd(0, 1, 0, 0, 1, 0);
        check("R6 nap in rd ignored", {2'b0, state_oh}, {2'b0, S_RD});
        check("R6 no viol", {7'b0, violation}, 8'd0);
    endtask

    task automatic t_relax_entry();
        do_reset();
        go_active();
        row_cmd(0, 1, 0, 1, 1, 0);
        check("R8 nap+relax", {2'b0, state_oh}, {2'b0, S_NAP});
        lp_exit = 1; step();
        check("R8 exit to rest", {2'b0, state_oh}, {2'b0, S_REST});
    endtask

    task automatic t_quiet();
        do_reset();
        quiet_len = 8'd3;
        row_cmd(0, 1, 0, 0, 1, 0);
        check("R9 busy open", {7'b0, quiet_busy}, 8'd1);
        act_vld = 1; act_hit = 0; step();
        check("R9 foreign ok", {7'b0, violation}, 8'd0);
        step();
        check("R9 busy last", {7'b0, quiet_busy}, 8'd1);
        step();
        check("R9 busy closed", {7'b0, quiet_busy}, 8'd0);
        ccmd_vld = 1; ccmd_hit = 1; step();
        check("R9 after window", {7'b0, violation}, 8'd0);
        do_reset();
        quiet_len = 8'd3;
        row_cmd(0, 1, 0, 0, 1, 0);
        step();
        step();
        ccmd_vld = 1; ccmd_hit = 1; step();
        check("R9 last cycle hit", {7'b0, violation}, 8'd1);
        do_reset();
        quiet_len = 8'd3;
        row_cmd(0, 1, 0, 0, 0, 1);
        act_vld = 1; act_bcast = 1; step();
        check("R9 bcast in window", {7'b0, violation}, 8'd1);
        lp_exit = 1; step();
        step();
        step();
        check("R12 sticky", {7'b0, violation}, 8'd1);
        do_reset();
        check("R12 reset clears", {7'b0, violation}, 8'd0);
    endtask

    task automatic t_precond();
        do_reset();
        banks_idle = 0; nap_sr_en = 0;
        row_cmd(0, 1, 0, 0, 1, 0);
        check("R10 nap exempt", {7'b0, violation}, 8'd0);
        do_reset();
        banks_idle = 0; nap_sr_en = 1;
        row_cmd(0, 1, 0, 0, 1, 0);
        check("R10 nap banks busy", {7'b0, violation}, 8'd1);
        do_reset();
        wbuf_empty = 0; nap_sr_en = 0;
        row_cmd(0, 1, 0, 0, 0, 1);
        check("R10 pdn wbuf", {7'b0, violation}, 8'd1);
        do_reset();
        go_active();
        wr_cmd = 1; step();
        banks_idle = 0;
        row_cmd(0, 1, 0, 0, 0, 1);
        check("R10 not accepted", {7'b0, violation}, 8'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        banks_idle = 1; wbuf_empty = 1; nap_sr_en = 1; quiet_len = 8'd0;
        @(negedge clk);
        t_reset();
        t_attn();
        t_rdwr();
        t_relax();
        t_entry();
        t_relax_entry();
        t_quiet();
        t_precond();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule